// File: doc/BRIEF.md
# Sample Pacer with Timed Sleep

This block paces a sensor's internal sampling. It turns a programmable period register into a one-cycle sample-update strobe. The period is built from three parts: a base interval chosen by one register bit, a 7-bit multiplier that scales it, and a fixed offset added on top. Every interval is counted in clock ticks and set by parameters, so the same logic serves any system clock. From the current period the block also derives a low-rate indication. Downstream logic uses it to pick the slow serial clock and the low-power operating point. It is high when the sample rate falls below the threshold, which means the period in ticks is above a parameterised limit.

A second register starts a timed sleep. Its low byte gives the duration in half-second units. While the sleep countdown runs, no strobes are issued. Once started, the countdown cannot be shortened, extended or restarted by further writes; only reset ends it early. When it expires, the pacer starts a fresh period from zero, so the first strobe after waking comes one full period later.

Top module: `sample_pacer`

## Requirements
- R1: With the period low byte holding base bit B (bit 7) and multiplier N (bits 6:0), the strobe is a one-cycle pulse repeating every P = (B ? LONG_TICKS : SHORT_TICKS) * N + OFFSET_TICKS clock cycles.
- R2: The strobe never stays high for two consecutive cycles.
- R3: A period write restarts the count. The first strobe under the new value comes P_new cycles after the write edge, and bits 15:8 of the written value have no effect.
- R4: A multiplier of 0 gives the same period as a multiplier of 1.
- R5: low_rate is high exactly when P exceeds LOWRATE_TICKS. It changes only in the cycle after a period write.
- R6: A sleep write with a nonzero low byte V, made while awake, holds sleeping high for exactly V * HALF_SEC_TICKS cycles. A low byte of 0 starts no sleep, and bits 15:8 of the written value are ignored.
- R7: No strobe is issued while sleeping is high.
- R8: A sleep write made while sleeping has no effect on the remaining sleep time.
- R9: After sleeping falls, the first strobe comes P cycles later, counting the cycle in which sleeping is first low as cycle 1.
- R10: While reset is held, and after it is released, strobe and sleeping are low and the period register holds PER_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| per_wr | input | 1 | Write strobe for the period register |
| per_wdata | input | 16 | Period value: bit 7 selects the base, bits 6:0 hold the multiplier |
| slp_wr | input | 1 | Write strobe for the sleep register |
| slp_wdata | input | 16 | Sleep value: bits 7:0 give the duration in half-second units |
| smp_strobe | output | 1 | One-cycle sample-update pulse |
| sleeping | output | 1 | High while the sleep countdown runs |
| low_rate | output | 1 | High when the sample rate is below the threshold |

## Verification
The bench builds the pacer with a short base of 4 ticks, a long base of 20, an offset of 2, a half-second of 16 ticks and a low-rate limit of 30 ticks. With these values a full period is a few dozen cycles and a multi-unit sleep lasts a few hundred. The low-rate limit sits between multiplier 7 and 8 on the short base, and between 1 and 2 on the long base, so both sides of the threshold are reached with small values. Sleep entry, a write attempted mid-sleep, and the strobe after waking all fall inside a short run.

// File: rtl/pacer_pkg.sv
// Shared layout of the period register low byte for the sample pacer.
package pacer_pkg;
    // Low byte of the period register: base select above a 7-bit multiplier.
    typedef struct packed {
        logic       long_base;
        logic [6:0] mult;
    } prd_byte_t;

    localparam int MULT_MAX  = 127;
    localparam int SLEEP_MAX = 255;
endpackage

// File: rtl/period_decode.sv
// Turns the period byte into a tick count and a low-rate flag.
// Assumes CNT_W is wide enough for LONG_TICKS*127+OFFSET_TICKS.
module period_decode
    import pacer_pkg::*;
#(
    parameter int SHORT_TICKS    = 244,
    parameter int LONG_TICKS     = 7568,
    parameter int OFFSET_TICKS   = 122,
    parameter int LOWRATE_TICKS  = 1831,
    parameter int CNT_W          = 20
) (
    input  logic [7:0]       prd_byte,
    output logic [CNT_W-1:0] period_ticks,
    output logic             low_rate
);
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_TICKS);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_TICKS);
    localparam logic [CNT_W-1:0] OFF_C   = CNT_W'(OFFSET_TICKS);
    localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOWRATE_TICKS);

    prd_byte_t        fields;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] mult_eff;

    assign fields = prd_byte_t'(prd_byte);

    // Pick the base, lift a zero multiplier to one, form the period.
    always_comb begin
        base         = fields.long_base ? LONG_C : SHORT_C;
        mult_eff     = (fields.mult == 7'd0) ? CNT_W'(1) : CNT_W'(fields.mult);
        period_ticks = base * mult_eff + OFF_C;
        low_rate     = period_ticks > LOW_C;
    end
endmodule

// File: rtl/sample_timer.sv
// Free-running period counter that emits a one-cycle strobe at the end of
// every period. A restart or a hold forces the count back to zero.
// Assumes period_ticks is at least 2.
module sample_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_ticks,
    input  logic             restart,
    input  logic             hold,
    output logic             strobe
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == period_ticks - CNT_W'(1));
    assign strobe = at_end && !hold;

    // Advance the count, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (hold || restart)  cnt <= '0;
        else if (at_end)           cnt <= '0;
        else                       cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/sleep_timer.sv
// Countdown for timed sleep. It loads only when idle and the requested
// duration is nonzero, and nothing but reset stops it.
module sleep_timer #(
    parameter int HALF_SEC_TICKS = 500000,
    parameter int SLP_W          = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] units,
    output logic       sleeping
);
    localparam logic [SLP_W-1:0] HALF_C = SLP_W'(HALF_SEC_TICKS);

    logic [SLP_W-1:0] left;
    logic             start;

    assign sleeping = (left != '0);
    assign start    = wr && !sleeping && (units != 8'd0);

    // Load on an accepted write, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        left <= '0;
        else if (start)    left <= SLP_W'(units) * HALF_C;
        else if (sleeping) left <= left - SLP_W'(1);
    end
endmodule

// File: rtl/sample_pacer.sv
// Top of the sample pacer: holds the period byte and ties the decoder,
// the period counter and the sleep countdown together.
// Assumes register writes are single-cycle pulses in the clk domain.
module sample_pacer
    import pacer_pkg::*;
#(
    parameter int          SHORT_TICKS    = 244,
    parameter int          LONG_TICKS     = 7568,
    parameter int          OFFSET_TICKS   = 122,
    parameter int          LOWRATE_TICKS  = 1831,
    parameter int          HALF_SEC_TICKS = 500000,
    parameter logic [15:0] PER_INIT       = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        per_wr,
    input  logic [15:0] per_wdata,
    input  logic        slp_wr,
    input  logic [15:0] slp_wdata,
    output logic        smp_strobe,
    output logic        sleeping,
    output logic        low_rate
);
    localparam int CNT_W = $clog2(LONG_TICKS * MULT_MAX + OFFSET_TICKS + 1);
    localparam int SLP_W = $clog2(HALF_SEC_TICKS * SLEEP_MAX + 1);

    logic [7:0]       prd_q;
    logic [CNT_W-1:0] period_ticks;
    logic             unused_hi;

    assign unused_hi = ^{per_wdata[15:8], slp_wdata[15:8]};

    // Hold the period byte; the upper byte is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      prd_q <= PER_INIT[7:0];
        else if (per_wr) prd_q <= per_wdata[7:0];
    end

    period_decode #(
        .SHORT_TICKS   (SHORT_TICKS),
        .LONG_TICKS    (LONG_TICKS),
        .OFFSET_TICKS  (OFFSET_TICKS),
        .LOWRATE_TICKS (LOWRATE_TICKS),
        .CNT_W         (CNT_W)
    ) u_decode (
        .prd_byte     (prd_q),
        .period_ticks (period_ticks),
        .low_rate     (low_rate)
    );

    sample_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_ticks (period_ticks),
        .restart      (per_wr),
        .hold         (sleeping),
        .strobe       (smp_strobe)
    );

    sleep_timer #(
        .HALF_SEC_TICKS (HALF_SEC_TICKS),
        .SLP_W          (SLP_W)
    ) u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (slp_wr),
        .units    (slp_wdata[7:0]),
        .sleeping (sleeping)
    );
endmodule

// File: rtl/sample_pacer_chk.sv
// Temporal checks on the sample pacer ports, bound to every instance.
module sample_pacer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        per_wr,
    input logic        slp_wr,
    input logic [15:0] slp_wdata,
    input logic        smp_strobe,
    input logic        sleeping,
    input logic        low_rate
);
    AST_NO_STROBE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n) sleeping |-> !smp_strobe); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) smp_strobe |=> !smp_strobe); // R2
    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) per_wr |=> !smp_strobe); // R3
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (slp_wr && !sleeping && slp_wdata[7:0] != 8'd0) |=> sleeping); // R6
    AST_ZERO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) (slp_wr && !sleeping && slp_wdata[7:0] == 8'd0) |=> !sleeping); // R6
    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $fell(sleeping) |-> !smp_strobe); // R9
    AST_RATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !per_wr |=> $stable(low_rate)); // R5
endmodule

bind sample_pacer sample_pacer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_wr     (per_wr),
    .slp_wr     (slp_wr),
    .slp_wdata  (slp_wdata),
    .smp_strobe (smp_strobe),
    .sleeping   (sleeping),
    .low_rate   (low_rate)
);

// File: tb/sample_pacer_bench.sv
// Bench for the sample pacer: a behavioural model compared on every cycle,
// plus directed interval measurements.
module sample_pacer_bench;
    localparam int SHORT = 4, LONG = 20, OFF = 2, LOWLIM = 30, HALF = 16;
    localparam logic [15:0] INIT = 16'h0001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic per_wr = 1'b0, slp_wr = 1'b0;
    logic [15:0] per_wdata = '0, slp_wdata = '0;
    logic smp_strobe, sleeping, low_rate;

    int checks = 0, errors = 0, cycles = 0;
    int m_per, m_cnt, m_slp;

    always #10 clk = ~clk;

    sample_pacer #(
        .SHORT_TICKS (SHORT), .LONG_TICKS (LONG), .OFFSET_TICKS (OFF),
        .LOWRATE_TICKS (LOWLIM), .HALF_SEC_TICKS (HALF), .PER_INIT (INIT)
    ) u_sample_pacer (
        .clk (clk), .rst_n (rst_n), .per_wr (per_wr), .per_wdata (per_wdata),
        .slp_wr (slp_wr), .slp_wdata (slp_wdata), .smp_strobe (smp_strobe),
        .sleeping (sleeping), .low_rate (low_rate)
    );

    function automatic int ticks_of(input int v);
        int n = v & 127;
        if (n == 0) n = 1;
        return (((v >> 7) & 1) != 0 ? LONG : SHORT) * n + OFF;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model update at each edge.
    always @(posedge clk) begin
        int p; bit asleep;
        cycles++;
        if (!rst_n) begin
            m_per = INIT; m_cnt = 0; m_slp = 0;
        end else begin
            p = ticks_of(m_per);
            asleep = (m_slp != 0);
            if (asleep || per_wr)   m_cnt = 0;
            else if (m_cnt == p - 1) m_cnt = 0;
            else                    m_cnt++;
            if (slp_wr && !asleep && slp_wdata[7:0] != 0) m_slp = slp_wdata[7:0] * HALF;
            else if (asleep) m_slp--;
            if (per_wr) m_per = per_wdata & 16'hFF;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && cycles > 0) begin
            check("R1/R7 strobe", smp_strobe, (m_slp == 0 && m_cnt == ticks_of(m_per) - 1) ? 1 : 0);
            check("R6/R8 sleeping", sleeping, (m_slp != 0) ? 1 : 0);
            check("R5 low_rate", low_rate, (ticks_of(m_per) > LOWLIM) ? 1 : 0);
        end
    end

    task automatic write_per(input logic [15:0] v);
        @(negedge clk); per_wr = 1'b1; per_wdata = v;
        @(negedge clk); per_wr = 1'b0;
    endtask

    task automatic write_slp(input logic [15:0] v);
        @(negedge clk); slp_wr = 1'b1; slp_wdata = v;
        @(negedge clk); slp_wr = 1'b0;
    endtask

    // Cycles until the next strobe, counting the current cycle as 1.
    task automatic until_strobe(output int k);
        k = 1;
        while (!smp_strobe && k < 5000) begin @(negedge clk); k++; end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k, s;
        repeat (3) @(negedge clk);
        check("R10 strobe in reset", smp_strobe, 0);
        check("R10 sleeping in reset", sleeping, 0);
        @(negedge clk); rst_n = 1'b1;
        check("R10 strobe after reset", smp_strobe, 0);
        check("R10 sleeping after reset", sleeping, 0);
        check("R10 init rate", low_rate, 0);
        // R1: default period 4*1+2 = 6
        until_strobe(k); check("R10 first period", k, 6);
        @(negedge clk); until_strobe(k); check("R1 period short N=1", k, 6);
        // R3: upper byte ignored, N=3 short -> 14 from write edge
        write_per(16'hAB03); until_strobe(k); check("R3 restart N=3", k, 14);
        @(negedge clk); until_strobe(k); check("R1 period N=3", k, 14);
        write_per(16'h0081); until_strobe(k); check("R1 long N=1", k, 22);
        check("R5 long N=1 not low", low_rate, 0);
        // R4: multiplier 0 acts as 1
        write_per(16'h0000); until_strobe(k); check("R4 zero multiplier", k, 6);
        // R5 thresholds
        write_per(16'h0007); check("R5 short N=7 (30)", low_rate, 0);
        write_per(16'h0008); check("R5 short N=8 (34)", low_rate, 1);
        write_per(16'h0082); check("R5 long N=2 (42)", low_rate, 1);
        write_per(16'h0002);
        // R6: zero sleep value, upper byte ignored
        write_slp(16'h0100); check("R6 zero sleep", sleeping, 0);
        // R6/R7/R8/R9: two units = 32 cycles
        repeat (3) @(negedge clk);
        write_slp(16'h0002);
        k = 0; s = 0;
        while (sleeping && k < 5000) begin
            if (k == 5) begin
                slp_wr = 1'b1; slp_wdata = 16'h00FF;
            end else begin
                slp_wr = 1'b0;
            end
            if (smp_strobe) s++;
            k++; @(negedge clk);
        end
        slp_wr = 1'b0;
        check("R6 R8 sleep length", k, 2 * HALF);
        check("R7 strobes asleep", s, 0);
        until_strobe(k); check("R9 wake period", k, 10);
        // R8: write after wake works again
        write_slp(16'h0001); check("R6 re-entry", sleeping, 1);
        repeat (HALF + 2) @(negedge clk);
        check("R6 woke", sleeping, 0);
        // R10: reset mid-sleep ends it
        write_slp(16'h0003);
        @(negedge clk); rst_n = 1'b0; @(negedge clk);
        check("R10 reset ends sleep", sleeping, 0);
        rst_n = 1'b1; until_strobe(k); check("R10 period after reset", k, 6);
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule